// File: doc/BRIEF.md
# TDM Audio Serial Data Transmitter

This block places two audio channel words on one serial data line inside a frame timed by an external bit clock and word clock. Several converters can then share the same time-division multiplexed bus, each writing into its own bit-clock slots. Both clocks are oversampled by the block's system clock. A frame begins when the word clock is seen rising at a capture edge. Slots are counted on the launch edges that follow. Each slot carries one data bit, most significant bit first.

Configuration inputs control the rest. They set where each word starts, whether the second word follows the first directly or after its own gap, and the order of the two channels. They also select which bit-clock edge launches data, and switch each channel on or off. Two more controls decide what the line does between words: it is either released to high impedance (optionally half a bit early) or held at logic 0. A one-cycle sync pulse marks the first slot of the earliest enabled word, so the converter filters can align to it.

Top module: `tdm_serial_tx`

## Requirements
- R1: While `rst` is high, and until the first launch edge after it falls, `sdout`, `sdout_oe` and `fsync` are 0.
- R2: A capture edge that sees `wclk` high, after the previous capture edge saw it low, starts a frame. The next launch edge carries slot 0. The first word occupies slots `off_first` to `off_first`+len-1, and each bit changes only at a launch edge.
- R3: With `slot_mode`=0 the second word starts in the slot right after the LSB of the first word (slot `off_first`+len).
- R4: With `slot_mode`=1 the second word starts at slot `off_first`+len+`off_second`, so `off_second` empty slots separate the two words.
- R5: With `swap_ch`=0 `ch0_word` is sent first. With `swap_ch`=1 `ch1_word` is sent first. `ch_en[0]` always belongs to `ch0_word` and `ch_en[1]` to `ch1_word`.
- R6: With `bclk_inv`=0 data launches on the falling `bclk` edge and frames are detected on the rising edge. With `bclk_inv`=1 the two edges swap roles, and the slot placement is unchanged.
- R7: With `tri_en`=1, `sdout_oe`=0 and `sdout`=0 in every slot that carries no data. Release happens at the launch edge that ends an LSB slot.
- R8: With `tri_en`=0, `sdout_oe`=1 and `sdout`=0 in every slot that carries no data.
- R9: With `tri_en`=1 and `early_tri`=1, `sdout_oe` drops at the capture edge in the middle of each LSB slot. With `tri_en`=0, `early_tri` has no effect.
- R10: A disabled channel's slots carry no data and follow R7 or R8. The other channel keeps its slot position.
- R11: `fsync` is a single-cycle pulse, once per frame, at the launch edge of the first slot of the first enabled word in send order. If no channel is enabled, it pulses at slot 0.
- R12: A word is the low `word_len` bits of its input, with bit `word_len`-1 sent first. A `word_len` above DATA_W counts as DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Bit clock |
| wclk | input | 1 | Word (frame) clock |
| bclk_inv | input | 1 | Swap the launch and capture edges of `bclk` |
| slot_mode | input | 1 | 0: words back to back; 1: gap of `off_second` before the second word |
| swap_ch | input | 1 | Send `ch1_word` first |
| ch_en | input | 2 | Per-channel enable, bit 0 for ch0 and bit 1 for ch1 |
| tri_en | input | 1 | Release the line to high impedance outside data |
| early_tri | input | 1 | Release half a bit early in each LSB slot |
| word_len | input | WL_W (5) | Word length in bits |
| off_first | input | OFF_W (6) | Slot of the first word's MSB |
| off_second | input | OFF_W (6) | Gap between the words in time-slot mode |
| ch0_word | input | DATA_W (16) | Channel 0 sample |
| ch1_word | input | DATA_W (16) | Channel 1 sample |
| sdout | output | 1 | Serial data bit |
| sdout_oe | output | 1 | Output enable for the tri-state pad |
| fsync | output | 1 | Filter sync pulse |

## Verification
A slot counter or frame detector that is off by one moves every word by one slot. This shows at the very next frame as a shifted MSB and a wrong `fsync` slot. A wrong channel pick shows as the other word's bits or a misplaced release of the line within the first word. An early-release flag that is wrong only shows in the half bit after the capture edge of an LSB slot. For that reason, `sdout_oe` is sampled in both halves of every slot.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE,
        SLOT_FIRST,
        SLOT_SECOND
    } slot_kind_e;

    typedef struct packed {
        logic oe;
        logic d;
        logic lsb;
    } tx_bit_t;

    function automatic logic in_window(int unsigned pos, int unsigned start, int unsigned len);
        return (pos >= start) && (pos < start + len);
    endfunction

endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic wclk,
    input  logic inv,
    output logic launch,
    output logic capture,
    output logic frame_start
);
    logic [STAGES-1:0] b_sr;
    logic [STAGES-1:0] w_sr;
    logic              b_last;
    logic              w_cap;
    logic              b_now;
    logic              w_now;
    logic              rise;
    logic              fall;

    assign b_now = b_sr[STAGES-1];
    assign w_now = w_sr[STAGES-1];
    assign rise  = b_now & ~b_last;
    assign fall  = ~b_now & b_last;

    assign launch      = inv ? rise : fall;
    assign capture     = inv ? fall : rise;
    assign frame_start = capture & w_now & ~w_cap;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    b_sr <= '0;
                    w_sr <= '0;
                end else begin
                    b_sr <= bclk;
                    w_sr <= wclk;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    b_sr <= '0;
                    w_sr <= '0;
                end else begin
                    b_sr <= {b_sr[STAGES-2:0], bclk};
                    w_sr <= {w_sr[STAGES-2:0], wclk};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            b_last <= 1'b0;
            w_cap  <= 1'b0;
        end else begin
            b_last <= b_now;
            if (capture) w_cap <= w_now;
        end
    end
endmodule

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              launch,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= SLOT_MAX;
        end else if (frame_start) begin
            slot <= '0;
        end else if (launch && slot != SLOT_MAX) begin
            slot <= slot + 1'b1;
        end
    end
endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map #(
    parameter int DATA_W = 16,
    parameter int OFF_W  = 6,
    parameter int WL_W   = 5,
    parameter int SLOT_W = 8
) (
    input  logic [WL_W-1:0]   word_len,
    input  logic [OFF_W-1:0]  off_first,
    input  logic [OFF_W-1:0]  off_second,
    input  logic              slot_mode,
    input  logic              swap_ch,
    input  logic [1:0]        ch_en,
    output logic [SLOT_W-1:0] len,
    output logic [SLOT_W-1:0] start_a,
    output logic [SLOT_W-1:0] start_b,
    output logic              en_a,
    output logic              en_b,
    output logic              a_is_ch1,
    output logic [SLOT_W-1:0] sync_slot
);
    localparam logic [SLOT_W-1:0] LEN_MAX = SLOT_W'(DATA_W);

    logic [SLOT_W-1:0] wl_ext;
    logic [SLOT_W-1:0] gap;

    always_comb begin
        wl_ext   = SLOT_W'(word_len);
        len      = (wl_ext > LEN_MAX) ? LEN_MAX : wl_ext;
        gap      = slot_mode ? SLOT_W'(off_second) : '0;
        start_a  = SLOT_W'(off_first);
        start_b  = start_a + len + gap;
        a_is_ch1 = swap_ch;
        en_a     = swap_ch ? ch_en[1] : ch_en[0];
        en_b     = swap_ch ? ch_en[0] : ch_en[1];
        if (en_a)      sync_slot = start_a;
        else if (en_b) sync_slot = start_b;
        else           sync_slot = '0;
    end
endmodule

// File: rtl/tdm_serial_tx.sv
module tdm_serial_tx
    import tdm_tx_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int OFF_W       = 6,
    parameter int SYNC_STAGES = 2,
    localparam int WL_W       = $clog2(DATA_W + 1),
    localparam int SLOT_W     = $clog2(2 * (2 ** OFF_W) + 2 * DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk,
    input  logic              wclk,
    input  logic              bclk_inv,
    input  logic              slot_mode,
    input  logic              swap_ch,
    input  logic [1:0]        ch_en,
    input  logic              tri_en,
    input  logic              early_tri,
    input  logic [WL_W-1:0]   word_len,
    input  logic [OFF_W-1:0]  off_first,
    input  logic [OFF_W-1:0]  off_second,
    input  logic [DATA_W-1:0] ch0_word,
    input  logic [DATA_W-1:0] ch1_word,
    output logic              sdout,
    output logic              sdout_oe,
    output logic              fsync
);
    logic              launch;
    logic              capture;
    logic              frame_start;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] len;
    logic [SLOT_W-1:0] start_a;
    logic [SLOT_W-1:0] start_b;
    logic [SLOT_W-1:0] sync_slot;
    logic              en_a;
    logic              en_b;
    logic              a_is_ch1;
    logic [DATA_W-1:0] word_a;
    logic [DATA_W-1:0] word_b;
    logic [DATA_W-1:0] word_sel;
    logic [SLOT_W-1:0] bit_pos;
    slot_kind_e        kind;
    tx_bit_t           nxt;
    logic              lsb_q;

    tdm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .bclk       (bclk),
        .wclk       (wclk),
        .inv        (bclk_inv),
        .launch     (launch),
        .capture    (capture),
        .frame_start(frame_start)
    );

    tdm_slot_counter #(.SLOT_W(SLOT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .launch     (launch),
        .slot       (slot)
    );

    tdm_slot_map #(
        .DATA_W(DATA_W),
        .OFF_W (OFF_W),
        .WL_W  (WL_W),
        .SLOT_W(SLOT_W)
    ) u_map (
        .word_len  (word_len),
        .off_first (off_first),
        .off_second(off_second),
        .slot_mode (slot_mode),
        .swap_ch   (swap_ch),
        .ch_en     (ch_en),
        .len       (len),
        .start_a   (start_a),
        .start_b   (start_b),
        .en_a      (en_a),
        .en_b      (en_b),
        .a_is_ch1  (a_is_ch1),
        .sync_slot (sync_slot)
    );

    // Per-slot decision for the bit launched at the current slot count.
    always_comb begin
        word_a = a_is_ch1 ? ch1_word : ch0_word;
        word_b = a_is_ch1 ? ch0_word : ch1_word;
        if (en_a && in_window(32'(slot), 32'(start_a), 32'(len))) begin
            kind     = SLOT_FIRST;
            word_sel = word_a;
            bit_pos  = start_a + len - 1'b1 - slot;
        end else if (en_b && in_window(32'(slot), 32'(start_b), 32'(len))) begin
            kind     = SLOT_SECOND;
            word_sel = word_b;
            bit_pos  = start_b + len - 1'b1 - slot;
        end else begin
            kind     = SLOT_IDLE;
            word_sel = '0;
            bit_pos  = '0;
        end
        nxt.oe  = (kind != SLOT_IDLE) || !tri_en;
        nxt.d   = (kind != SLOT_IDLE) && |(word_sel & (DATA_W'(1) << bit_pos));
        nxt.lsb = (kind != SLOT_IDLE) && (bit_pos == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdout    <= 1'b0;
            sdout_oe <= 1'b0;
            fsync    <= 1'b0;
            lsb_q    <= 1'b0;
        end else begin
            fsync <= 1'b0;
            if (launch) begin
                sdout    <= nxt.d;
                sdout_oe <= nxt.oe;
                lsb_q    <= nxt.lsb;
                fsync    <= (slot == sync_slot);
            end else if (capture && lsb_q && tri_en && early_tri) begin
                sdout    <= 1'b0;
                sdout_oe <= 1'b0;
            end
        end
    end

    AST_HIZ_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
        !sdout_oe |-> !sdout); // R7
    AST_DATA_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (sdout != $past(sdout)) |-> $past(launch || capture)); // R2
    AST_OE_RISE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        $rose(sdout_oe) |-> $past(launch)); // R7
    AST_EARLY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($fell(sdout_oe) && !$past(launch)) |-> $past(early_tri && tri_en)); // R9
    AST_DRIVE_NO_TRI: assert property (@(posedge clk) disable iff (rst)
        ($past(launch) && !$past(tri_en)) |-> sdout_oe); // R8
    AST_SYNC_ON_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        fsync |-> $past(launch)); // R11
endmodule

// File: tb/tb_tdm_serial_tx.sv
`timescale 1ns/1ps
module tb_tdm_serial_tx;

    typedef struct packed {
        logic [3:0]  tag;
        logic [5:0]  off1;
        logic [5:0]  off2;
        logic [4:0]  wl;
        logic        slot;
        logic        swap;
        logic        inv;
        logic [1:0]  en;
        logic        tri_on;
        logic        early;
        logic [15:0] w0;
        logic [15:0] w1;
    } vec_t;

    localparam int NV = 13;
    localparam int NSLOT = 64;
    localparam vec_t VT [NV] = '{
        '{4'd2,  6'd0,  6'd0, 5'd16, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 16'hA5C3, 16'h3C96}, // R2 R3
        '{4'd3,  6'd5,  6'd0, 5'd16, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 16'h8001, 16'hFFFE}, // R3 R8
        '{4'd4,  6'd2,  6'd7, 5'd16, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 16'h1234, 16'hFEDC}, // R4
        '{4'd5,  6'd1,  6'd3, 5'd12, 1'b1, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0, 16'h0ABC, 16'h0F0F}, // R5
        '{4'd6,  6'd3,  6'd0, 5'd16, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b1, 16'hC001, 16'h7FFF}, // R6
        '{4'd12, 6'd10, 6'd4, 5'd8,  1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 16'hFF81, 16'h0055}, // R12
        '{4'd9,  6'd0,  6'd2, 5'd10, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 16'h03FF, 16'h0201}, // R9
        '{4'd10, 6'd4,  6'd5, 5'd16, 1'b1, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 16'hFFFF, 16'h9669}, // R10 R11
        '{4'd10, 6'd6,  6'd1, 5'd16, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 16'h5A5A, 16'hFFFF}, // R10 R11
        '{4'd11, 6'd9,  6'd2, 5'd16, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF}, // R11
        '{4'd11, 6'd9,  6'd2, 5'd16, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF}, // R11
        '{4'd9,  6'd2,  6'd0, 5'd16, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 16'hFFFF, 16'h0001}, // R9
        '{4'd12, 6'd1,  6'd3, 5'd20, 1'b1, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0, 16'hB00D, 16'h6E11}  // R12
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base = 1'b1;
    logic        wclk = 1'b0;
    logic        bclk;
    logic        bclk_inv = 1'b0;
    logic        slot_mode = 1'b0;
    logic        swap_ch = 1'b0;
    logic [1:0]  ch_en = 2'b11;
    logic        tri_en = 1'b0;
    logic        early_tri = 1'b0;
    logic [4:0]  word_len = 5'd16;
    logic [5:0]  off_first = '0;
    logic [5:0]  off_second = '0;
    logic [15:0] ch0_word = '0;
    logic [15:0] ch1_word = '0;
    logic        sdout;
    logic        sdout_oe;
    logic        fsync;

    int total = 0;
    int bad = 0;
    int cur_p = -2;
    int sync_cnt = 0;
    int sync_at = -5;
    bit done = 0;

    always #2.5 clk = ~clk;
    assign bclk = base ^ bclk_inv;

    tdm_serial_tx dut (
        .clk(clk), .rst(rst), .bclk(bclk), .wclk(wclk), .bclk_inv(bclk_inv),
        .slot_mode(slot_mode), .swap_ch(swap_ch), .ch_en(ch_en), .tri_en(tri_en),
        .early_tri(early_tri), .word_len(word_len), .off_first(off_first),
        .off_second(off_second), .ch0_word(ch0_word), .ch1_word(ch1_word),
        .sdout(sdout), .sdout_oe(sdout_oe), .fsync(fsync)
    );

    always @(negedge clk) begin
        if (fsync) begin
            sync_cnt = sync_cnt + 1;
            sync_at  = cur_p;
        end
    end

    task automatic chk(input string what, input int tag, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL R%0d %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // {in_data, oe, d, lsb}
    function automatic logic [3:0] exp_bit(input vec_t v, input int p);
        int len;
        int sa;
        int sb;
        logic [15:0] wa;
        logic [15:0] wb;
        logic ea;
        logic eb;
        len = (v.wl > 16) ? 16 : int'(v.wl);
        sa = int'(v.off1);
        sb = sa + len + (v.slot ? int'(v.off2) : 0);
        wa = v.swap ? v.w1 : v.w0;
        wb = v.swap ? v.w0 : v.w1;
        ea = v.swap ? v.en[1] : v.en[0];
        eb = v.swap ? v.en[0] : v.en[1];
        if (ea && p >= sa && p < sa + len)
            return {1'b1, 1'b1, wa[sa + len - 1 - p], 1'(p == sa + len - 1)};
        if (eb && p >= sb && p < sb + len)
            return {1'b1, 1'b1, wb[sb + len - 1 - p], 1'(p == sb + len - 1)};
        return {1'b0, !v.tri_on, 1'b0, 1'b0};
    endfunction

    function automatic int exp_sync(input vec_t v);
        int len;
        logic ea;
        logic eb;
        len = (v.wl > 16) ? 16 : int'(v.wl);
        ea = v.swap ? v.en[1] : v.en[0];
        eb = v.swap ? v.en[0] : v.en[1];
        if (ea) return int'(v.off1);
        if (eb) return int'(v.off1) + len + (v.slot ? int'(v.off2) : 0);
        return 0;
    endfunction

    task automatic apply(input vec_t v);
        @(negedge clk);
        bclk_inv = v.inv; slot_mode = v.slot; swap_ch = v.swap; ch_en = v.en;
        tri_en = v.tri_on; early_tri = v.early; word_len = v.wl;
        off_first = v.off1; off_second = v.off2; ch0_word = v.w0; ch1_word = v.w1;
    endtask

    // One bit period of 16 system clocks; launch at its start, capture in its middle.
    task automatic bit_period(input int p, input vec_t v, input bit check);
        logic [3:0] e;
        int tg;
        @(negedge clk);
        base = 1'b0;
        wclk = (p == -1);
        cur_p = p;
        repeat (6) @(negedge clk);
        if (check) begin
            e = exp_bit(v, p);
            if (e[3]) tg = int'(v.tag);
            else if (v.tag == 4'd10) tg = 10;
            else tg = v.tri_on ? 7 : 8;
            chk($sformatf("oe slot %0d", p), tg, int'(sdout_oe), int'(e[2]));
            chk($sformatf("data slot %0d", p), tg, int'(sdout), int'(e[1]));
        end
        repeat (2) @(negedge clk);
        base = 1'b1;
        repeat (6) @(negedge clk);
        if (check) begin
            e = exp_bit(v, p);
            if (e[0] && v.tri_on && v.early)
                chk($sformatf("early release slot %0d", p), 9, int'(sdout_oe), 0);
            else
                chk($sformatf("late-half oe slot %0d", p), (v.early ? 9 : (e[3] ? int'(v.tag) : (v.tri_on ? 7 : 8))),
                    int'(sdout_oe), int'(e[2]));
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        vec_t idle_v;
        // R1: outputs in reset and just after it, before any launch edge
        repeat (4) @(negedge clk);
        chk("reset sdout", 1, int'(sdout), 0);
        chk("reset oe", 1, int'(sdout_oe), 0);
        chk("reset fsync", 1, int'(fsync), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("post-reset oe before launch", 1, int'(sdout_oe), 0);
        chk("post-reset sdout before launch", 1, int'(sdout), 0);

        // R7 R11: no frame yet, tri-state on: line released, no sync pulse
        idle_v = '{4'd7, 6'd0, 6'd0, 5'd16, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF};
        apply(idle_v);
        for (int i = 0; i < 4; i++) begin
            bit_period(-2, idle_v, 1'b0);
            chk("idle oe without frame", 7, int'(sdout_oe), 0);
        end
        chk("no sync without frame", 11, sync_cnt, 0);

        // Table of frames, one loop
        for (int k = 0; k < NV; k++) begin
            apply(VT[k]);
            bit_period(-2, VT[k], 1'b0);
            bit_period(-1, VT[k], 1'b0);
            sync_cnt = 0;
            sync_at = -5;
            for (int p = 0; p < NSLOT; p++) bit_period(p, VT[k], 1'b1);
            chk($sformatf("sync count vec %0d", k), 11, sync_cnt, 1);
            chk($sformatf("sync slot vec %0d", k), 11, sync_at, exp_sync(VT[k]));
        end

        // R1: reset in the middle of a frame clears the outputs
        apply(VT[1]);
        bit_period(-1, VT[1], 1'b0);
        for (int p = 0; p < 8; p++) bit_period(p, VT[1], 1'b0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("mid-frame reset oe", 1, int'(sdout_oe), 0);
        chk("mid-frame reset sdout", 1, int'(sdout), 0);
        rst = 1'b0;

        finish_run();
    end
endmodule